// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Warm-Up

This block keeps a 1024-row DRAM refreshed. After reset it holds the strobes inactive for a programmable power-up pause. It then runs eight warm-up refresh cycles and raises `init_done`. From then on an interval timer marks when a refresh is due. The block asks the access sequencer for the memory bus with `refresh_req` and holds that request until `grant` is seen. Once granted, it drives the row and column strobes itself and releases the bus one cycle after precharge completes.

Two refresh styles are available through `row_only`. With `row_only` low the block uses the memory's internal row counter: the column strobe drops before the row strobe. With `row_only` high the column strobe stays high, and the block drives the row address from its own 10-bit counter. The style is sampled when the grant is taken, so it is fixed for the whole cycle. Warm-up cycles use the same style as periodic ones.

Refreshes the sequencer has not yet served are counted, up to a cap of four, so that a late grant does not lose refreshes. Timings are cycle counts, so they are parameters. The defaults assume a 10 ns clock: a 20000-cycle pause, a 1560-cycle interval, a 1-cycle column lead, 6 cycles of row strobe low and 4 cycles of precharge.

The controller is a state machine with these states:
- `ST_POWERUP`: pause after reset.
- `ST_IDLE`: nothing owed.
- `ST_REQ`: request raised, waiting for the grant.
- `ST_LEAD`: column strobe low ahead of the row strobe (counter-based style only).
- `ST_RASLOW`: row strobe low.
- `ST_PRECH`: both strobes high.
- `ST_RELEASE`: request still high for one cycle.

Its transitions are:
- POWERUP→IDLE when the pause ends.
- IDLE→REQ when a warm-up refresh is still needed or a refresh is owed.
- REQ→LEAD on grant in counter-based style, and REQ→RASLOW on grant in row-only style.
- LEAD→RASLOW, RASLOW→PRECH and PRECH→RELEASE, each when its phase count ends.
- RELEASE→IDLE always.

Top module: `rfsh_sched`

## Requirements
- R1: After reset release no request is raised and both strobes stay high for at least PU_CYC cycles; the first request appears within PU_CYC+3 cycles.
- R2: Exactly WARM_N (8) refresh cycles run before `init_done` rises, and `init_done` then stays high until reset.
- R3: The warm-up refreshes use the style selected by `row_only` (column strobe low at the row strobe fall when `row_only`=0, high when `row_only`=1).
- R4: In counter-based style, `cas_n` is low for exactly LEAD_CYC cycles before `ras_n` falls, and it stays low for the whole time `ras_n` is low.
- R5: In row-only style, `cas_n` stays high, and `row_addr` holds its value for the whole time `ras_n` is low.
- R6: `ras_n` is low for exactly RASL_CYC cycles. Counting from the cycle `ras_n` rises, `refresh_req` stays high for PRE_CYC+1 cycles and then drops.
- R7: While `grant` is low, a raised request stays high and both strobes stay high.
- R8: Once `init_done` is high, a refresh falls due every IVL_CYC cycles. Every due refresh is performed exactly once, including when a new one falls due in the same cycle that one completes, provided the owed count stays below the cap.
- R9: No more than OWE_MAX (4) refreshes are owed. After a long grant outage exactly four refreshes follow each other, and no more until the next due point.
- R10: `row_addr` resets to 0. It advances by exactly one per completed row-only refresh, wrapping from 1023 to 0. A counter-based refresh leaves it unchanged.
- R11: `row_only` is sampled when the grant is taken, so changing it during a refresh cycle does not change that cycle's strobes.
- R12: During reset `refresh_req`=0, `ras_n`=1, `cas_n`=1, `init_done`=0 and `row_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant | input | 1 | Bus handed to the refresh block by the access sequencer |
| row_only | input | 1 | 1 = row-strobe-only refresh with external row address, 0 = column-before-row refresh |
| refresh_req | output | 1 | Refresh wants or holds the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row address for row-only refresh |
| init_done | output | 1 | Power-up pause and warm-up refreshes complete |

## Verification
Two events can land on the same clock edge: a new refresh falling due, and the completion of an owed one. When they coincide, the owed count must both rise and fall in that cycle.

The bench provokes this by sweeping the grant delay in steps that are coprime with the interval. Completions therefore drift across every phase of the due timer, including the coincident one. The sweep is judged arithmetically: the number of row-strobe falls over a window bounded by known due points must equal the number of due points in that window. A lost or doubled refresh shifts that count.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_REQ,
        ST_LEAD,
        ST_RASLOW,
        ST_PRECH,
        ST_RELEASE
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_timer.sv
// Power-up pause and periodic due-point generator.
module rfsh_timer #(
    parameter int PU_CYC  = 20000,
    parameter int IVL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pu_done,
    output logic tick
);
    localparam int PU_W  = $clog2(PU_CYC + 1);
    localparam int IVL_W = $clog2(IVL_CYC + 1);
    localparam logic [PU_W-1:0]  PU_LAST  = PU_W'(PU_CYC - 1);
    localparam logic [IVL_W-1:0] IVL_LAST = IVL_W'(IVL_CYC - 1);

    logic [PU_W-1:0]  pu_cnt;
    logic [IVL_W-1:0] ivl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_cnt  <= '0;
            pu_done <= 1'b0;
        end else if (!pu_done) begin
            if (pu_cnt == PU_LAST) pu_done <= 1'b1;
            else                   pu_cnt  <= pu_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_cnt <= '0;
        end else if (run) begin
            if (ivl_cnt == IVL_LAST) ivl_cnt <= '0;
            else                     ivl_cnt <= ivl_cnt + 1'b1;
        end
    end

    assign tick = run && (ivl_cnt == IVL_LAST);

endmodule

// File: rtl/rfsh_debt.sv
// Saturating count of refreshes that are due but not yet served.
module rfsh_debt #(
    parameter int OWE_MAX = 4,
    parameter int DEBT_W  = $clog2(OWE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              served,
    output logic [DEBT_W-1:0] debt,
    output logic              pending
);
    localparam logic [DEBT_W-1:0] CAP = DEBT_W'(OWE_MAX);

    logic              inc;
    logic [DEBT_W-1:0] debt_nx;

    always_comb begin
        inc     = tick && ((debt != CAP) || served);
        debt_nx = debt + DEBT_W'(inc) - DEBT_W'(served);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt <= '0;
        else        debt <= debt_nx;
    end

    assign pending = (debt != '0);

endmodule

// File: rtl/rfsh_rowctr.sv
// Row counter for row-strobe-only refresh; wraps at 2**ROW_W.
module rfsh_rowctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int PU_CYC   = 20000,
    parameter int IVL_CYC  = 1560,
    parameter int WARM_N   = 8,
    parameter int OWE_MAX  = 4,
    parameter int LEAD_CYC = 1,
    parameter int RASL_CYC = 6,
    parameter int PRE_CYC  = 4,
    parameter int ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             row_only,
    output logic             refresh_req,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             init_done
);
    localparam int DEBT_W = $clog2(OWE_MAX + 1);
    localparam int WARM_W = $clog2(WARM_N + 1);
    localparam int PH_MAX = (LEAD_CYC > RASL_CYC) ?
                            ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC) :
                            ((RASL_CYC > PRE_CYC) ? RASL_CYC : PRE_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARM_N - 1);

    rfsh_state_e        state, state_nx;
    logic [PH_W-1:0]    ph_cnt;
    logic [WARM_W-1:0]  warm_cnt;
    logic               mode_q;
    logic               pu_done, tick, pending, served, row_adv;
    logic [DEBT_W-1:0]  debt;

    rfsh_timer #(.PU_CYC(PU_CYC), .IVL_CYC(IVL_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(init_done),
        .pu_done(pu_done), .tick(tick)
    );

    rfsh_debt #(.OWE_MAX(OWE_MAX), .DEBT_W(DEBT_W)) u_debt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .served(served),
        .debt(debt), .pending(pending)
    );

    rfsh_rowctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row_addr)
    );

    assign served  = (state == ST_RELEASE) && init_done;
    assign row_adv = (state == ST_RELEASE) && mode_q;

    function automatic logic [PH_W-1:0] ph_load(rfsh_state_e s);
        unique case (s)
            ST_LEAD:   return PH_W'(LEAD_CYC - 1);
            ST_RASLOW: return PH_W'(RASL_CYC - 1);
            ST_PRECH:  return PH_W'(PRE_CYC - 1);
            default:   return '0;
        endcase
    endfunction

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWERUP: if (pu_done) state_nx = ST_IDLE;
            ST_IDLE:    if (!init_done || pending) state_nx = ST_REQ;
            ST_REQ:     if (grant) state_nx = row_only ? ST_RASLOW : ST_LEAD;
            ST_LEAD:    if (ph_cnt == '0) state_nx = ST_RASLOW;
            ST_RASLOW:  if (ph_cnt == '0) state_nx = ST_PRECH;
            ST_PRECH:   if (ph_cnt == '0) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and per-cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            ph_cnt    <= '0;
            warm_cnt  <= '0;
            mode_q    <= 1'b0;
            init_done <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx != state)  ph_cnt <= ph_load(state_nx);
            else if (ph_cnt != '0)  ph_cnt <= ph_cnt - 1'b1;
            if (state == ST_REQ && grant) mode_q <= row_only;
            if (state == ST_RELEASE && !init_done) begin
                warm_cnt <= warm_cnt + 1'b1;
                if (warm_cnt == WARM_LAST) init_done <= 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        refresh_req = 1'b0;
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        unique case (state)
            ST_POWERUP, ST_IDLE: ;
            ST_REQ:     refresh_req = 1'b1;
            ST_LEAD:    begin refresh_req = 1'b1; cas_n = 1'b0; end
            ST_RASLOW:  begin refresh_req = 1'b1; ras_n = 1'b0; cas_n = mode_q; end
            ST_PRECH:   refresh_req = 1'b1;
            ST_RELEASE: refresh_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int ROW_W   = 10,
    parameter int DEBT_W  = 3,
    parameter int OWE_MAX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              refresh_req,
    input logic              ras_n,
    input logic              cas_n,
    input logic              init_done,
    input logic [ROW_W-1:0]  row_addr,
    input logic              mode_q,
    input logic              pu_done,
    input logic [DEBT_W-1:0] debt
);
    a_r1_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (!refresh_req && ras_n && cas_n));

    a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

    a_r4_cas_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n) |=> !(!ras_n && cas_n));

    a_r5_cas_high_row_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && mode_q) |-> cas_n);

    a_r5_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |=> $stable(row_addr));

    a_r6_ras_inside_req: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> refresh_req);

    a_r7_wait_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && ras_n && cas_n && !grant) |=> (ras_n && cas_n));

    a_r7_req_starts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_req) |-> (ras_n && cas_n));

    a_r9_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DEBT_W'(OWE_MAX));

    a_r10_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr != $past(row_addr)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));
endmodule

bind rfsh_sched rfsh_sched_chk #(.ROW_W(ROW_W), .DEBT_W(DEBT_W), .OWE_MAX(OWE_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .refresh_req(refresh_req),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done), .row_addr(row_addr),
    .mode_q(mode_q), .pu_done(pu_done), .debt(debt)
);

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;
    localparam int PU   = 30;
    localparam int IVL  = 80;
    localparam int WARM = 8;
    localparam int LEAD = 1;
    localparam int RASL = 6;
    localparam int PRE  = 4;
    localparam int RW   = 10;
    localparam int ROWS = 1 << RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic row_only = 1'b0;
    logic refresh_req, ras_n, cas_n, init_done;
    logic [RW-1:0] row_addr;

    always #10 clk = ~clk;   // 50 MHz

    rfsh_sched #(.PU_CYC(PU), .IVL_CYC(IVL), .WARM_N(WARM), .OWE_MAX(4),
                 .LEAD_CYC(LEAD), .RASL_CYC(RASL), .PRE_CYC(PRE), .ROW_W(RW))
    u_rfsh_sched (
        .clk(clk), .rst_n(rst_n), .grant(grant), .row_only(row_only),
        .refresh_req(refresh_req), .ras_n(ras_n), .cas_n(cas_n),
        .row_addr(row_addr), .init_done(init_done)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // ---------------- monitor (samples at falling edge) ----------------
    int nfall, nrise, rise_cyc, first_req, warm_cbr, warm_ro;
    int lead_cnt, low_cnt, post_cnt;
    bit p_ras, p_req, in_post, fall_cas, mism, row_moved, wrapped, last_mism;
    logic [RW-1:0] p_row, fall_row;

    always @(negedge clk) begin
        if (!rst_n) begin
            nfall = 0; nrise = 0; rise_cyc = 0; first_req = -1;
            warm_cbr = 0; warm_ro = 0; lead_cnt = 0; low_cnt = 0; post_cnt = 0;
            p_ras = 1; p_req = 0; in_post = 0; mism = 0; wrapped = 0;
            p_row = '0; last_mism = 0;
            check(!refresh_req && ras_n && cas_n && !init_done && row_addr == '0,
                  "R12 reset state", {refresh_req, ras_n, cas_n, init_done}, 6);
        end else begin
            if (refresh_req && !p_req) begin
                nrise++;
                rise_cyc = cyc;
                if (first_req < 0) first_req = cyc;
            end
            if (p_ras && !ras_n) begin
                nfall++;
                if (!init_done) begin
                    if (!cas_n) warm_cbr++; else warm_ro++;
                end
                if (!cas_n) check(lead_cnt == LEAD, "R4 column lead", lead_cnt, LEAD);
                low_cnt = 1; fall_cas = cas_n; fall_row = row_addr;
                mism = 0; row_moved = 0;
            end else if (!ras_n) begin
                low_cnt++;
                if (cas_n != fall_cas) mism = 1;
                if (row_addr != fall_row) row_moved = 1;
            end else if (!p_ras && ras_n) begin
                check(low_cnt == RASL, "R6 row strobe width", low_cnt, RASL);
                check(!mism, fall_cas ? "R5 column stays high" : "R4 column stays low",
                      mism, 0);
                if (fall_cas) check(!row_moved, "R5 row address hold", row_moved, 0);
                last_mism = mism;
                in_post = 1; post_cnt = 1;
            end else if (in_post) begin
                if (refresh_req) post_cnt++;
                else begin
                    check(post_cnt == PRE + 1, "R6 release after precharge", post_cnt, PRE + 1);
                    in_post = 0;
                end
            end
            if (!cas_n && ras_n) lead_cnt++;
            else if (cas_n)      lead_cnt = 0;
            if (row_addr != p_row) begin
                check(row_addr == RW'(p_row + 1'b1), "R10 row step",
                      int'(row_addr), int'(RW'(p_row + 1'b1)));
                if (p_row == RW'(ROWS - 1)) wrapped = 1;
            end
            p_ras = ras_n; p_req = refresh_req; p_row = row_addr;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0; grant = 1'b1; row_only = mode;
        repeat (3) step();
        @(negedge clk); rst_n = 1'b1; #1;
    endtask

    task automatic wait_rise();
        int r = nrise;
        while (nrise == r) step();
    endtask

    task automatic wait_fall();
        int f = nfall;
        while (nfall == f) step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c0, c1, f0, fb, m, target;

        // ---- run 1: counter-based style ----
        do_reset(1'b0);
        while (!init_done) step();
        check(first_req >= PU && first_req <= PU + 3, "R1 power-up pause", first_req, PU);
        check(nfall == WARM, "R2 warm-up count", nfall, WARM);
        check(warm_cbr == WARM && warm_ro == 0, "R3 warm-up style counter", warm_cbr, WARM);

        // R9 / R7: withhold grant for ten intervals
        wait_rise();
        c0 = rise_cyc;
        grant = 1'b0;
        while (cyc < c0 + 10 * IVL + 2) step();
        check(refresh_req && ras_n && cas_n, "R7 hold request without grant",
              {refresh_req, ras_n, cas_n}, 7);
        grant = 1'b1;
        f0 = nfall;
        repeat (IVL - 10) step();
        check(nfall - f0 == 4, "R9 owed cap", nfall - f0, 4);

        // R8: due spacing and grant-delay sweep
        wait_rise();
        c1 = rise_cyc;
        check(c1 == c0 + 11 * IVL, "R8 due interval", c1 - c0, 11 * IVL);
        fb = nfall;
        for (int i = 0; i < 16; i++) begin
            grant = 1'b0;
            while (!refresh_req) step();
            repeat ((i * 37) % IVL) step();
            grant = 1'b1;
            while (refresh_req) step();
        end
        grant = 1'b1;
        m = (cyc - (c1 - 1)) / IVL + 6;
        target = c1 - 1 + m * IVL + IVL / 2;
        while (cyc < target) step();
        check(nfall - fb == m + 1, "R8 no lost or extra refresh", nfall - fb, m + 1);

        // ---- run 2: row-only style ----
        do_reset(1'b1);
        while (!init_done) step();
        check(warm_ro == WARM && warm_cbr == 0, "R3 warm-up style row-only", warm_ro, WARM);
        check(row_addr == RW'(WARM), "R10 row after warm-up", int'(row_addr), WARM);

        wait_fall();
        row_only = 1'b0;              // change style mid-cycle
        while (!ras_n) step();
        check(fall_cas && !last_mism, "R11 style fixed at grant", last_mism, 0);
        while (refresh_req) step();
        check(row_addr == RW'(WARM + 1), "R10 row-only advance", int'(row_addr), WARM + 1);

        wait_fall();
        check(!cas_n, "R11 new style at next grant", cas_n, 0);
        while (refresh_req) step();
        check(row_addr == RW'(WARM + 1), "R10 counter style keeps row", int'(row_addr), WARM + 1);

        row_only = 1'b1;
        while (!wrapped && cyc < 150000) step();
        check(wrapped, "R10 wrap 1023 to 0", wrapped, 1);
        check(row_addr <= RW'(1), "R10 row after wrap", int'(row_addr), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule